// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block lets a clocked master use a byte-wide asynchronous static RAM of 32768 locations. The master presents an address, a write flag and write data with a request. The controller accepts it when it is idle, then runs one complete memory cycle on active-low chip-select, output-enable and write-strobe pins. It owns a split bidirectional data bus, with separate out, in and drive-enable signals. When the cycle is done it answers with a one-cycle acknowledge, and a read returns its data with that pulse.

Every timing minimum of the memory is a parameter in picoseconds. The clock period is also a parameter. Cycle counts are derived by rounding each minimum up to whole clock cycles. A write is framed by chip-select and write-strobe both low, with output-enable held high throughout. The write ends when the strobe rises while chip-select is still low and address and data are still held. After every read there is a recovery gap in which the memory releases the bus. Only after that gap can the controller drive the bus again.

Top module: `sram_async_ctrl`

## Requirements
- R1: In the cycle after any clock edge with `rst_n` low, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0, `ack` is 0 and `ready` is 1.
- R2: An accepted read (`req`=1, `req_we`=0 while `ready`=1) drives `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for exactly RD_CYC cycles. It starts in the cycle after acceptance, and `mem_addr` equals the request address throughout.
- R3: Read data is captured at the edge that ends the last read cycle. It is presented on `rdata` with a one-cycle `ack`=1 in the following cycle, and equals the byte last written to that address.
- R4: An accepted write drives `mem_ce_n`=0, `mem_we_n`=0 and `mem_oe_n`=1 for exactly WP_CYC cycles, with `mem_addr` and `mem_dq_out` equal to the request.
- R5: `mem_dq_oe` is 1 exactly in write-pulse and write-end cycles, and never while `mem_oe_n` is 0. In those cycles `mem_dq_out` carries the request's write data.
- R6: A read is followed by TURN_CYC cycles with all three strobes at 1 and `mem_dq_oe`=0 before the next request can start.
- R7: `ready` is 1 only when no cycle is in progress. A request raised while `ready`=0 is not started until `ready` returns, and each handshake starts exactly one cycle.
- R8: A write ends with one cycle of `mem_we_n`=1 and `mem_ce_n`=0, in which address and data are still driven and `ack`=1.
- R9: With clock period P, RD_CYC = ceil(max(tAA,tRC,tOE)/P)+1, WP_CYC = max(ceil(tWP/P), ceil(tAW/P), ceil(tDW/P), ceil(tWC/P)-1, 1) and TURN_CYC = max(ceil(tHZ/P),1). At the default 10 ns clock this gives 2, 1 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Request valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Request address |
| req_wdata | input | 8 | Write data |
| ready | output | 1 | Controller idle, request will be accepted |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Read data, valid with ack after a read |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_addr | output | 15 | Memory address |
| mem_dq_out | output | 8 | Data driven toward memory |
| mem_dq_in | input | 8 | Data returned by memory |
| mem_dq_oe | output | 1 | Enable for the controller's data driver |

## Verification
The hardest case to reach is the moment a write's strobe rises. A missing end cycle or an early driver release only shows as a lost write, and that appears on a later read of the same address. The bench therefore carries a bus-level memory model that stores a byte only if the driver is still on when the strobe rises. Write/read pairs to the same address, including the top and bottom address, then expose any such fault. The model also returns junk until two cycles after output enable falls, so a capture one cycle early gives a wrong read value. A reset asserted in the middle of a write pulse checks that the strobes return to idle.

// File: rtl/sram_ctrl_pkg.sv
// Shared types and helpers for the asynchronous SRAM controller.
// Assumes: timing values are given in picoseconds as positive integers.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_TURN,
        ST_WPULSE,
        ST_WEND
    } ctrl_state_e;

    // Whole clock cycles covering a time, rounded up.
    function automatic int cyc_ceil(input int t_ps, input int clk_ps);
        return (t_ps + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
// Down counter that times each phase of a memory cycle.
// Assumes: load values are phase length minus one; done means the current
// cycle is the last of the phase.
module sram_ctrl_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    // Load at a phase start, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_fsm.sv
// Cycle sequencer: chooses the phase, runs the timer and produces
// registered, glitch-free memory strobes, driver enable and acknowledge.
// Assumes: phase lengths are at least one cycle each.
module sram_ctrl_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int CNT_W    = 2,
    parameter int RD_CYC   = 2,
    parameter int WP_CYC   = 1,
    parameter int TURN_CYC = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             req_we,
    input  logic             t_done,
    output logic             t_load,
    output logic [CNT_W-1:0] t_val,
    output logic             accept,
    output logic             cap_en,
    output logic             ready,
    output logic             ack,
    output logic             ce_n,
    output logic             oe_n,
    output logic             we_n,
    output logic             drv
);

    localparam logic [CNT_W-1:0] RD_LOAD   = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WP_LOAD   = CNT_W'(WP_CYC - 1);
    localparam logic [CNT_W-1:0] TURN_LOAD = CNT_W'(TURN_CYC - 1);

    ctrl_state_e state_q, state_nxt;

    // Next phase and timer loads from the current phase.
    always_comb begin
        state_nxt = state_q;
        t_load    = 1'b0;
        t_val     = '0;
        accept    = 1'b0;
        cap_en    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    accept = 1'b1;
                    t_load = 1'b1;
                    if (req_we) begin
                        state_nxt = ST_WPULSE;
                        t_val     = WP_LOAD;
                    end else begin
                        state_nxt = ST_READ;
                        t_val     = RD_LOAD;
                    end
                end
            end
            ST_READ: begin
                if (t_done) begin
                    cap_en    = 1'b1;
                    state_nxt = ST_TURN;
                    t_load    = 1'b1;
                    t_val     = TURN_LOAD;
                end
            end
            ST_TURN: begin
                if (t_done) state_nxt = ST_IDLE;
            end
            ST_WPULSE: begin
                if (t_done) state_nxt = ST_WEND;
            end
            ST_WEND: begin
                state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Phase register and strobes registered from the next phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ce_n    <= 1'b1;
            oe_n    <= 1'b1;
            we_n    <= 1'b1;
            drv     <= 1'b0;
            ack     <= 1'b0;
        end else begin
            state_q <= state_nxt;
            ce_n    <= !(state_nxt inside {ST_READ, ST_WPULSE, ST_WEND});
            oe_n    <= !(state_nxt == ST_READ);
            we_n    <= !(state_nxt == ST_WPULSE);
            drv     <= (state_nxt inside {ST_WPULSE, ST_WEND});
            ack     <= t_done && (state_q inside {ST_READ, ST_WPULSE});
        end
    end

    assign ready = (state_q == ST_IDLE);

    p_ack_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    p_we_inside_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !ce_n);

    p_oe_off_in_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> oe_n);

    p_ready_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (ce_n && !drv));

endmodule

// File: rtl/sram_ctrl_datapath.sv
// Holds address and write data for the whole cycle and captures read data.
// Assumes: accept only occurs while idle, so held values stay stable
// through every phase of a cycle.
module sram_ctrl_datapath #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              cap_en,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);

    // Latch request fields at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Capture memory output on the last read cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (cap_en) begin
            rdata_q <= dq_in;
        end
    end

endmodule

// File: rtl/sram_async_ctrl.sv
// Top level: synchronous request port to an asynchronous byte-wide SRAM.
// Assumes: timing parameters are the memory's minimums in picoseconds and
// CLK_PS is the system clock period; all counts round up.
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W  = 15,
    parameter int DATA_W  = 8,
    parameter int CLK_PS  = 10000,
    parameter int T_AA_PS = 10000,
    parameter int T_RC_PS = 10000,
    parameter int T_OE_PS = 5000,
    parameter int T_WP_PS = 8000,
    parameter int T_AW_PS = 9000,
    parameter int T_DW_PS = 6000,
    parameter int T_WC_PS = 10000,
    parameter int T_HZ_PS = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);

    // R9: phase lengths in cycles, each minimum rounded up; one extra read
    // cycle of margin for sampling the asynchronous output.
    localparam int RD_CYC = imax(imax(cyc_ceil(T_AA_PS, CLK_PS),
                                      cyc_ceil(T_RC_PS, CLK_PS)),
                                 cyc_ceil(T_OE_PS, CLK_PS)) + 1;
    localparam int WP_CYC = imax(imax(cyc_ceil(T_WP_PS, CLK_PS),
                                      cyc_ceil(T_AW_PS, CLK_PS)),
                                 imax(cyc_ceil(T_DW_PS, CLK_PS),
                                      imax(cyc_ceil(T_WC_PS, CLK_PS) - 1, 1)));
    localparam int TURN_CYC = imax(cyc_ceil(T_HZ_PS, CLK_PS), 1);
    localparam int MAX_CYC  = imax(imax(RD_CYC, WP_CYC), TURN_CYC);
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             t_done;
    logic             accept;
    logic             cap_en;

    sram_ctrl_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .done     (t_done)
    );

    sram_ctrl_fsm #(
        .CNT_W    (CNT_W),
        .RD_CYC   (RD_CYC),
        .WP_CYC   (WP_CYC),
        .TURN_CYC (TURN_CYC)
    ) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req),
        .req_we (req_we),
        .t_done (t_done),
        .t_load (t_load),
        .t_val  (t_val),
        .accept (accept),
        .cap_en (cap_en),
        .ready  (ready),
        .ack    (ack),
        .ce_n   (mem_ce_n),
        .oe_n   (mem_oe_n),
        .we_n   (mem_we_n),
        .drv    (mem_dq_oe)
    );

    sram_ctrl_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .cap_en    (cap_en),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .dq_in     (mem_dq_in),
        .addr_q    (mem_addr),
        .wdata_q   (mem_dq_out),
        .rdata_q   (rdata)
    );

    p_no_contention_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

    p_end_holds_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_we_n) && !mem_ce_n) |-> (mem_dq_oe && $stable(mem_dq_out)));

    p_release_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> (mem_ce_n && !mem_dq_oe));

endmodule

// File: tb/sram_async_ctrl_test.sv
// Bench: a bus-level SRAM model, a queue-based per-cycle reference of
// the expected pin activity, and directed plus mixed request traffic.
module sram_async_ctrl_test;

    // R9: expected lengths at a 8 ns clock, worked out from the minimums.
    localparam int P      = 8000;
    localparam int RD_N   = (10000 + P - 1) / P + 1;              // 3
    localparam int WP_N   = (9000 + P - 1) / P;                    // 2
    localparam int TURN_N = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_we = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        ready, ack;
    logic [7:0]  rdata;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [14:0] mem_addr;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = 8'hEE;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int rst_seen = 0;

    always #4 clk = ~clk;

    sram_async_ctrl #(.CLK_PS(P)) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready),
        .ack(ack), .rdata(rdata), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
        .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
    );

    function automatic logic [7:0] dflt(input logic [14:0] a);
        return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h3C;
    endfunction

    // ---------------- bus-level memory model ----------------
    logic [7:0] sram_arr [int];
    int  rd_age = 0;
    logic prev_we_low = 1'b0;

    always @(posedge clk) begin
        if (!mem_ce_n && !mem_oe_n && mem_we_n) rd_age <= rd_age + 1;
        else rd_age <= 0;
        if (prev_we_low && mem_we_n && mem_dq_oe)
            sram_arr[int'(mem_addr)] = mem_dq_out;
        prev_we_low <= !mem_we_n && !mem_ce_n;
        rst_seen <= rst_n ? 0 : rst_seen + 1;
        cycles <= cycles + 1;
    end

    // Output valid only two cycles after the read strobes settle.
    always @(negedge clk) begin
        if (!mem_ce_n && !mem_oe_n && mem_we_n && rd_age >= 2)
            mem_dq_in = sram_arr.exists(int'(mem_addr)) ?
                        sram_arr[int'(mem_addr)] : dflt(mem_addr);
        else
            mem_dq_in = 8'hEE;
    end

    // ---------------- reference of pin activity ----------------
    typedef struct packed {
        logic ce_n, oe_n, we_n, drv, ack, rdy, rdchk;
        logic [14:0] addr;
        logic [7:0]  data;
        logic [2:0]  tag;
    } exp_t;

    exp_t q[$];
    logic [7:0] ref_mem [int];

    function automatic string tag_name(input logic [2:0] t);
        case (t)
            3'd1: return "R2 R9 read";
            3'd2: return "R3 R6 turnaround";
            3'd3: return "R4 R9 write pulse";
            3'd4: return "R8 write end";
            3'd5: return "R1 reset";
            default: return "R7 idle";
        endcase
    endfunction

    function automatic exp_t mk(input logic c, o, w, d, a, r, k,
                                input logic [14:0] ad, input logic [7:0] dt,
                                input logic [2:0] t);
        exp_t e;
        e.ce_n = c; e.oe_n = o; e.we_n = w; e.drv = d; e.ack = a;
        e.rdy = r; e.rdchk = k; e.addr = ad; e.data = dt; e.tag = t;
        return e;
    endfunction

    task automatic cmp_pins(input exp_t e);
        checks++;
        if ({mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, ack, ready} !=
            {e.ce_n, e.oe_n, e.we_n, e.drv, e.ack, e.rdy}) begin
            errors++;
            $display("FAIL %s: ce/oe/we/drv/ack/rdy=%b%b%b%b%b%b expected %b%b%b%b%b%b t=%0t",
                     tag_name(e.tag), mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe,
                     ack, ready, e.ce_n, e.oe_n, e.we_n, e.drv, e.ack, e.rdy, $time);
        end
    endtask

    always @(negedge clk) begin
        exp_t e;
        if (!rst_n) begin
            q.delete();
            if (rst_seen >= 1) cmp_pins(mk(1, 1, 1, 0, 0, 1, 0, '0, '0, 3'd5));
        end else begin
            e = (q.size() != 0) ? q.pop_front() : mk(1, 1, 1, 0, 0, 1, 0, '0, '0, 3'd0);
            cmp_pins(e);
            if (!e.ce_n) begin
                checks++;
                if (mem_addr !== e.addr) begin
                    errors++;
                    $display("FAIL %s: mem_addr=%h expected %h", tag_name(e.tag), mem_addr, e.addr);
                end
            end
            if (e.drv) begin
                checks++;
                if (mem_dq_out !== e.data) begin
                    errors++;
                    $display("FAIL R5 write data: mem_dq_out=%h expected %h", mem_dq_out, e.data);
                end
            end
            if (e.rdchk) begin
                checks++;
                if (rdata !== e.data) begin
                    errors++;
                    $display("FAIL R3 read data @%h: rdata=%h expected %h", e.addr, rdata, e.data);
                end
            end
            // R7: a request is taken only when the model is idle.
            if (e.rdy && req) begin
                if (req_we) begin
                    ref_mem[int'(req_addr)] = req_wdata;
                    for (int i = 0; i < WP_N; i++)
                        q.push_back(mk(0, 1, 0, 1, 0, 0, 0, req_addr, req_wdata, 3'd3));
                    q.push_back(mk(0, 1, 1, 1, 1, 0, 0, req_addr, req_wdata, 3'd4));
                end else begin
                    logic [7:0] v;
                    v = ref_mem.exists(int'(req_addr)) ? ref_mem[int'(req_addr)] : dflt(req_addr);
                    for (int i = 0; i < RD_N; i++)
                        q.push_back(mk(0, 0, 1, 0, 0, 0, 0, req_addr, '0, 3'd1));
                    for (int i = 0; i < TURN_N; i++)
                        q.push_back(mk(1, 1, 1, 0, (i == 0), 0, (i == 0), req_addr, v, 3'd2));
                end
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic issue(input logic w, input logic [14:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        req = 1'b1; req_we = w; req_addr = a; req_wdata = d;
        while (1) begin
            @(negedge clk);
            if (ready) break;
        end
        @(posedge clk); #1;
        req = 1'b0; req_we = ~w; req_addr = ~a; req_wdata = ~d;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        int seed;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);
        issue(1'b0, 15'h0000, 8'h00);             // R3 unwritten location
        issue(1'b1, 15'h1234, 8'hA5);             // R4 R8
        issue(1'b0, 15'h1234, 8'h00);             // R3 readback
        issue(1'b1, 15'h7FFF, 8'hFF);             // top address
        issue(1'b1, 15'h0000, 8'h00);             // bottom address
        issue(1'b0, 15'h7FFF, 8'h00);
        issue(1'b0, 15'h0000, 8'h00);
        issue(1'b0, 15'h1234, 8'h00);             // R6 read then write
        issue(1'b1, 15'h1234, 8'h5A);
        issue(1'b0, 15'h1234, 8'h00);
        seed = 7;
        for (int i = 0; i < 40; i++) begin        // R7 mixed traffic, held-off requests
            seed = (seed * 1103515245 + 12345) & 32'h7FFFFFFF;
            issue(seed[4], {11'h2A5, seed[9:6]}, seed[23:16]);
        end
        // R1: reset in the middle of a write pulse.
        @(posedge clk); #1;
        req = 1'b1; req_we = 1'b1; req_addr = 15'h0100; req_wdata = 8'h77;
        while (1) begin
            @(negedge clk);
            if (ready) break;
        end
        @(posedge clk); #1 req = 1'b0; rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        issue(1'b0, 15'h7FFF, 8'h00);
        issue(1'b1, 15'h0200, 8'h3E);
        issue(1'b0, 15'h0200, 8'h00);
        repeat (8) @(posedge clk);
        finish_run();
    end

    initial begin
        wait (cycles > 20000);
        errors++;
        $display("FAIL watchdog: run did not complete, cycles=%0d expected <20000", cycles);
        finish_run();
    end

endmodule